// File: doc/BRIEF.md
# Texture Access Locality Mode Predictor

This block sits between a vertex-processing front end and a texture fetch unit. It receives texel coordinate requests (u, v) one at a time and attaches a fetch mode to each one. In cache mode the fetch unit brings in a whole texture block with a burst. In direct mode it reads only the single texel. The choice depends on how many texels of a block are likely to be used before the block is evicted.

Two tests make the choice. The delta test estimates the number of texels touched in a block from the coordinate step since the previous request. It compares that estimate with the smallest access count that makes a burst cheaper than repeated single reads. The divider is avoided by multiplying both sides of the comparison. The look-ahead test runs when the request leaves its queue. It looks at the requests still waiting behind it, and if any of them falls in the same block it forces cache mode. Requests wait in a small queue that is the look-ahead window. The head request is issued when the queue is full, or when no new request arrives that cycle. Results are registered and held under output backpressure.

Top module: `tex_mode_predictor`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0, in_ready is 1 and the look-ahead queue is empty.
- R2: The queue holds at most DEPTH (default 4) requests. in_ready is 0 exactly when DEPTH requests are queued, and a request is taken on a cycle with in_valid and in_ready both high.
- R3: The oldest queued request is issued into the output register when the output register is free (empty, or out_ready high) and either the queue is full or in_valid is low. Requests leave in arrival order, and out_valid rises on the cycle after the issue.
- R4: While out_valid is 1 and out_ready is 0, out_valid, out_u, out_v and out_mode stay unchanged.
- R5: The delta test uses du = |u − u_prev| and dv = |v − v_prev|, taken against the previously issued request, with a zero delta replaced by 1. It votes cache when NACC_MIN × du × dv ≤ NBLOCK, where NBLOCK = 4^BLK_LOG2 (16 by default). out_mode is 1 for cache mode and 0 for direct mode.
- R6: NACC_MIN is ceil((C_DIRECT + NBLOCK − 1) / C_DIRECT), which is 3 with the defaults. So a step product du × dv of 5 votes cache and a product of 6 votes direct.
- R7: The first request issued after reset has no predecessor. Its delta vote is direct, so it is issued as direct unless the look-ahead test matches.
- R8: Look-ahead: if any request still queued behind the issuing one has the same block index (u >> BLK_LOG2, v >> BLK_LOG2), the request is issued in cache mode whatever the delta vote.
- R9: Requests already issued do not take part in the look-ahead. A request that shares a block only with its predecessor gets cache mode only through the delta vote.
- R10: The deltas are absolute, so a request whose coordinates are below those of its predecessor is judged exactly as the mirror-image ascending step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Queue can take a request |
| in_u | input | COORD_W | Request u coordinate |
| in_v | input | COORD_W | Request v coordinate |
| out_valid | output | 1 | Issued request present |
| out_ready | input | 1 | Consumer takes the issued request |
| out_u | output | COORD_W | Issued u coordinate |
| out_v | output | COORD_W | Issued v coordinate |
| out_mode | output | 1 | 1 = cache (burst) mode, 0 = direct mode |

## Verification
The assertions watch, on every cycle, the queue occupancy bound and its step on a push, that the output stays stable under backpressure, and that an issue follows when the queue is full or the input is idle. They also check that a look-ahead match always yields cache mode and that the first issue after reset without a match is direct. The arithmetic side of the decision needs the bench's scenarios. These cover the product boundary at 5 against 6, absolute deltas for descending steps, zero-delta clamping, the reach of the look-ahead window (a match three entries back counts, four does not) and the exclusion of already-issued requests. They also show that arrival order is kept when the output is stalled.

// File: rtl/tmp_pkg.sv
package tmp_pkg;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_CACHE  = 1'b1
  } fetch_mode_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/lmp_window.sv
module lmp_window #(
  parameter int COORD_W  = 8,
  parameter int BLK_LOG2 = 2,
  parameter int DEPTH    = 4,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic               pop,
  input  logic [COORD_W-1:0] wr_u,
  input  logic [COORD_W-1:0] wr_v,
  output logic [CNT_W-1:0]   count,
  output logic [COORD_W-1:0] head_u,
  output logic [COORD_W-1:0] head_v,
  output logic               same_blk
);

  localparam int BLK_W = COORD_W - BLK_LOG2;

  logic [COORD_W-1:0] mem_u [DEPTH];
  logic [COORD_W-1:0] mem_v [DEPTH];
  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [DEPTH-1:0]   hit;

  always_ff @(posedge clk) begin
    if (push) begin
      mem_u[wr_ptr] <= wr_u;
      mem_v[wr_ptr] <= wr_v;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head_u = mem_u[rd_ptr];
  assign head_v = mem_v[rd_ptr];

  assign hit[0] = 1'b0;
  for (genvar k = 1; k < DEPTH; k++) begin : g_look
    logic [PTR_W-1:0] idx;
    logic [PTR_W:0]   sum;
    assign sum    = {1'b0, rd_ptr} + (PTR_W + 1)'(k);
    assign idx    = (sum >= (PTR_W + 1)'(DEPTH)) ? PTR_W'(sum - (PTR_W + 1)'(DEPTH)) : PTR_W'(sum);
    assign hit[k] = (CNT_W'(k) < count) &&
                    (mem_u[idx][COORD_W-1 -: BLK_W] == head_u[COORD_W-1 -: BLK_W]) &&
                    (mem_v[idx][COORD_W-1 -: BLK_W] == head_v[COORD_W-1 -: BLK_W]);
  end

  assign same_blk = |hit;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/lmp_delta.sv
module lmp_delta #(
  parameter int COORD_W  = 8,
  parameter int NBLOCK   = 16,
  parameter int NACC_MIN = 3,
  localparam int PROD_W  = 2 * COORD_W + $clog2(NACC_MIN + 1) + $clog2(NBLOCK + 1)
) (
  input  logic [COORD_W-1:0] cur_u,
  input  logic [COORD_W-1:0] cur_v,
  input  logic [COORD_W-1:0] prev_u,
  input  logic [COORD_W-1:0] prev_v,
  input  logic               prev_ok,
  output logic               worth
);

  logic [COORD_W-1:0] du, dv, du_c, dv_c;
  logic [PROD_W-1:0]  prod;

  always_comb begin
    du   = (cur_u >= prev_u) ? cur_u - prev_u : prev_u - cur_u;
    dv   = (cur_v >= prev_v) ? cur_v - prev_v : prev_v - cur_v;
    du_c = (du == '0) ? COORD_W'(1) : du;
    dv_c = (dv == '0) ? COORD_W'(1) : dv;
    prod = PROD_W'(NACC_MIN) * PROD_W'(du_c) * PROD_W'(dv_c);
    worth = prev_ok && (prod <= PROD_W'(NBLOCK));
  end

endmodule

// File: rtl/tex_mode_predictor.sv
module tex_mode_predictor #(
  parameter int COORD_W  = 8,
  parameter int BLK_LOG2 = 2,
  parameter int DEPTH    = 4,
  parameter int C_DIRECT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_u,
  input  logic [COORD_W-1:0] in_v,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [COORD_W-1:0] out_u,
  output logic [COORD_W-1:0] out_v,
  output logic               out_mode
);
  import tmp_pkg::*;

  localparam int NBLOCK   = 1 << (2 * BLK_LOG2);
  localparam int NACC_MIN = ceil_div(C_DIRECT + NBLOCK - 1, C_DIRECT);
  localparam int CNT_W    = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]   count;
  logic [COORD_W-1:0] head_u, head_v, prev_u, prev_v;
  logic               prev_ok, same_blk, worth, push, pop, out_free;
  fetch_mode_e        pick;

  assign in_ready = (count < CNT_W'(DEPTH));
  assign push     = in_valid && in_ready;
  assign out_free = !out_valid || out_ready;
  assign pop      = (count != '0) && ((count == CNT_W'(DEPTH)) || !in_valid) && out_free;

  lmp_window #(.COORD_W(COORD_W), .BLK_LOG2(BLK_LOG2), .DEPTH(DEPTH)) u_window (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .wr_u(in_u), .wr_v(in_v),
    .count(count), .head_u(head_u), .head_v(head_v), .same_blk(same_blk)
  );

  lmp_delta #(.COORD_W(COORD_W), .NBLOCK(NBLOCK), .NACC_MIN(NACC_MIN)) u_delta (
    .cur_u(head_u), .cur_v(head_v), .prev_u(prev_u), .prev_v(prev_v),
    .prev_ok(prev_ok), .worth(worth)
  );

  assign pick = (worth || same_blk) ? MODE_CACHE : MODE_DIRECT;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_u     <= '0;
      out_v     <= '0;
      out_mode  <= 1'b0;
      prev_u    <= '0;
      prev_v    <= '0;
      prev_ok   <= 1'b0;
    end else if (pop) begin
      out_valid <= 1'b1;
      out_u     <= head_u;
      out_v     <= head_v;
      out_mode  <= pick;
      prev_u    <= head_u;
      prev_v    <= head_v;
      prev_ok   <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_u) && $stable(out_v) && $stable(out_mode)));

  // R3
  full_issue_chk: assert property (@(posedge clk) disable iff (rst)
    ((count == CNT_W'(DEPTH)) && (!out_valid || out_ready)) |=> (out_valid && (count == CNT_W'(DEPTH - 1))));

  // R3
  idle_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && (count != '0) && (!out_valid || out_ready)) |=> out_valid);

  // R8
  look_cache_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && same_blk) |=> out_mode);

  // R7
  first_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !prev_ok && !same_blk) |=> !out_mode);

endmodule

// File: tb/tex_mode_predictor_bench.sv
module tex_mode_predictor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 8;
  localparam int LOOK       = 3;
  localparam int NB         = 16;
  localparam int NMIN       = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b1;
  logic [CW-1:0] in_u = '0, in_v = '0;
  logic          in_ready, out_valid, out_mode;
  logic [CW-1:0] out_u, out_v;

  int checks = 0;
  int errors = 0;
  int bu [16];
  int bv [16];
  int rec_u [64];
  int rec_v [64];
  int rec_m [64];
  int rec_n = 0;
  logic hold_prev = 1'b0;
  int hp_u, hp_v, hp_m;
  logic mp_ok = 1'b0;
  int mp_u = 0, mp_v = 0;

  tex_mode_predictor u_tex_mode_predictor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_u(in_u), .in_v(in_v), .out_valid(out_valid), .out_ready(out_ready),
    .out_u(out_u), .out_v(out_v), .out_mode(out_mode)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Output monitor: samples a quarter period after the falling edge.
  always @(negedge clk) begin
    #(CLK_PERIOD / 4);
    if (!rst) begin
      if (hold_prev)  // R4
        check(out_valid && out_u == hp_u && out_v == hp_v && out_mode == hp_m,
              "R4 hold under backpressure", out_u, hp_u);
      hold_prev = out_valid && !out_ready;
      hp_u = out_u; hp_v = out_v; hp_m = out_mode;
      if (out_valid && out_ready && rec_n < 64) begin
        rec_u[rec_n] = out_u; rec_v[rec_n] = out_v; rec_m[rec_n] = out_mode;
        rec_n++;
      end
    end
  end

  function automatic int absd(input int a, input int b);
    return (a >= b) ? a - b : b - a;
  endfunction

  function automatic int exp_mode(input int idx, input int n);
    int du, dv;
    for (int k = 1; k <= LOOK; k++)
      if (idx + k < n && (bu[idx+k] >> 2) == (bu[idx] >> 2) && (bv[idx+k] >> 2) == (bv[idx] >> 2))
        return 1;
    if (!mp_ok) return 0;
    du = absd(bu[idx], mp_u); if (du == 0) du = 1;
    dv = absd(bv[idx], mp_v); if (dv == 0) dv = 1;
    return (NMIN * du * dv <= NB) ? 1 : 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rec_n = 0; hold_prev = 1'b0; mp_ok = 1'b0;
  endtask

  task automatic send_burst(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_u = CW'(bu[i]); in_v = CW'(bv[i]);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain_and_compare(input int n, input string tag);
    int e;
    repeat (30) @(negedge clk);
    check(rec_n == n, {tag, " R3 issue count"}, rec_n, n);
    for (int i = 0; i < n && i < rec_n; i++) begin
      e = exp_mode(i, n);
      check(rec_u[i] == bu[i] && rec_v[i] == bv[i], {tag, " R3 order"}, rec_u[i], bu[i]);
      check(rec_m[i] == e, tag, rec_m[i], e);
      mp_ok = 1'b1; mp_u = bu[i]; mp_v = bv[i];
    end
  endtask

  task automatic t_reset();
    do_reset();
    #(CLK_PERIOD / 4);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_first();
    do_reset();
    bu[0] = 10; bv[0] = 10;
    send_burst(1);
    drain_and_compare(1, "R7 lone first request direct");
    check(rec_m[0] == 0, "R7 first request", rec_m[0], 0);
  endtask

  task automatic t_first_look();
    do_reset();
    bu[0] = 1; bv[0] = 1; bu[1] = 2; bv[1] = 2;
    send_burst(2);
    drain_and_compare(2, "R8 first request rescued by look-ahead");
    check(rec_m[0] == 1, "R8 first request cache", rec_m[0], 1);
  endtask

  task automatic t_boundary();
    do_reset();
    bu[0] = 0;  bv[0] = 0;   bu[1] = 5;  bv[1] = 1;   bu[2] = 11; bv[2] = 2;
    bu[3] = 11; bv[3] = 40;  bu[4] = 16; bv[4] = 48;
    send_burst(5);
    drain_and_compare(5, "R5 delta threshold");
    check(rec_m[1] == 1, "R6 product 5 cache", rec_m[1], 1);
    check(rec_m[2] == 0, "R6 product 6 direct", rec_m[2], 0);
    check(rec_m[3] == 0, "R5 zero du clamp", rec_m[3], 0);
  endtask

  task automatic t_descend();
    do_reset();
    bu[0] = 60; bv[0] = 60; bu[1] = 55; bv[1] = 59; bu[2] = 49; bv[2] = 58;
    send_burst(3);
    drain_and_compare(3, "R10 descending steps");
    check(rec_m[1] == 1, "R10 descending product 5", rec_m[1], 1);
    check(rec_m[2] == 0, "R10 descending product 6", rec_m[2], 0);
  endtask

  task automatic t_issued_excluded();
    do_reset();
    bu[0] = 0; bv[0] = 0; bu[1] = 3; bv[1] = 3;
    send_burst(2);
    drain_and_compare(2, "R9 issued requests excluded");
    check(rec_m[1] == 0, "R9 shared block with predecessor only", rec_m[1], 0);
  endtask

  task automatic t_window_reach();
    do_reset();
    bu[0] = 0;  bv[0] = 0;  bu[1] = 40; bv[1] = 40; bu[2] = 80; bv[2] = 80;
    bu[3] = 2;  bv[3] = 2;
    send_burst(4);
    drain_and_compare(4, "R8 match three back");
    check(rec_m[0] == 1, "R8 match at window edge", rec_m[0], 1);
    do_reset();
    bu[0] = 0;  bv[0] = 0;  bu[1] = 40; bv[1] = 40; bu[2] = 80; bv[2] = 80;
    bu[3] = 120; bv[3] = 120; bu[4] = 1; bv[4] = 1;
    send_burst(5);
    drain_and_compare(5, "R8 match four back");
    check(rec_m[0] == 0, "R8 match beyond window", rec_m[0], 0);
  endtask

  task automatic t_full_stall();
    do_reset();
    out_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin bu[i] = 20 * i + 3; bv[i] = 7 * i; end
    send_burst(5);
    #(CLK_PERIOD / 4);
    check(in_ready == 1'b0, "R2 in_ready low when queue full", in_ready, 0);
    check(out_valid == 1'b1 && out_u == bu[0], "R3 oldest request held at output", out_u, bu[0]);
    @(negedge clk);
    out_ready = 1'b1;
    drain_and_compare(5, "R2 stalled burst");
  endtask

  task automatic t_backpressure();
    do_reset();
    for (int i = 0; i < 9; i++) begin bu[i] = (i * 13) % 50; bv[i] = (i * 5) % 17; end
    fork
      send_burst(9);
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        out_ready = (c % 3) != 1;
      end
    join
    @(negedge clk);
    out_ready = 1'b1;
    drain_and_compare(9, "R4 toggled out_ready");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_first();
    t_first_look();
    t_boundary();
    t_descend();
    t_issued_excluded();
    t_window_reach();
    t_full_stall();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule